// File: doc/BRIEF.md
# Prefixed Opcode Fetch and Addressing-Mode Decoder

This block is the front of an 8-bit processor's instruction pipeline. A `start` pulse loads a fetch address. The block then reads opcode bytes one at a time through a byte-read port. That port has a request channel and a response channel.

If the first byte is one of the two page prefixes (0x10 or 0x11), the block fetches one more byte. It then forms a 16-bit instruction word, with the prefix in the upper byte and the second byte in the lower byte. Any other first byte produces a word with a zero upper byte. The block classifies the word into one of six addressing modes. It presents the word and the mode on a decode output channel, together with the address of the next byte to fetch. Operand fetch and execution belong to later stages.

Back-pressure rules on the streaming interfaces:
- **Request channel:** a raised `req_valid` stays high, with `req_addr` unchanged, until `req_ready` is seen.
- **Response channel:** `rsp_ready` is high only while exactly one accepted request is waiting for its byte.
- **Decode channel:** `dec_valid` stays high, with word and mode held, until `dec_ready` is seen. The cycle of that handshake is flagged by `done`.

Top module: `opcode_fetch_decode`

## Requirements
- R1: During and after reset, `busy`, `req_valid` and `dec_valid` are low.
- R2: A `start` pulse while idle has these effects:
  - it loads `start_pc`;
  - it raises `busy`;
  - on the next cycle it issues a read request at that address.
  
  A `start` pulse while busy has no effect.
- R3: A request is held with a stable address until accepted. Each accepted request advances the fetch address by one, wrapping from 0xFFFF to 0x0000.
- R4: A response is accepted only while a request is outstanding (`rsp_ready` high). At any other time, `rsp_valid` is ignored.
- R5: A first byte of 0x10 or 0x11 causes a second fetch, and `dec_word` = {first, second}. Any other first byte gives `dec_word` = {0x00, first}.
- R6: Exactly two bytes are fetched after a prefix, even when the second byte is itself 0x10 or 0x11.
- R7: `dec_mode` codes are inherent=0, immediate=1, direct=2, relative=3, indexed=4, extended=5. The mode depends on bits 7:4 of the word:

  | Bits 7:4 | Mode |
  |---|---|
  | 0x0, 0x9, 0xD | direct |
  | 0x2 | relative |
  | 0x6, 0xA, 0xE | indexed |
  | 0x7, 0xB, 0xF | extended |
  | 0x8, 0xC | immediate |

- R8: The word 0x008D decodes as relative. The prefixed word 0x108D stays immediate.
- R9: When bits 7:4 are 0x3, 0x4 or 0x5, the whole 16-bit word is compared:
  - below 0x0034 is indexed;
  - otherwise, below 0x0038 or equal to 0x003C is immediate;
  - everything else is inherent, which includes every prefixed word in these rows.
- R10: When bits 7:4 are 0x1, bits 3:0 select the mode:
  - 6 and 7 are relative;
  - A, C, E and F are immediate;
  - every other value is inherent.
- R11: A prefixed word is classified from its second byte by the rules of R7 to R10.
- R12: Word and mode stay stable while `dec_valid` is high and `dec_ready` is low. `done` pulses for one cycle on the decode handshake. The block is then idle, with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an opcode fetch (honoured only when idle) |
| start_pc | input | ADDR_W | Address of the first opcode byte |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Byte address being read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 8 | Read data byte |
| rsp_ready | output | 1 | Block is waiting for a byte |
| dec_valid | output | 1 | Decoded word and mode valid |
| dec_ready | input | 1 | Consumer takes the decode result |
| dec_word | output | 16 | Instruction word |
| dec_mode | output | 3 | Addressing-mode code (see R7) |
| done | output | 1 | One-cycle strobe on decode handshake |
| busy | output | 1 | Fetch or decode in progress |
| pc | output | ADDR_W | Address of the next byte to fetch |

## Verification
The checks assume the memory returns exactly one byte for each accepted request, in order, and raises `rsp_valid` in no cycle before that request has been accepted. The bench serves bytes from tasks that wait for a request handshake before presenting data. The only `rsp_valid` pulses it drives at other times are deliberate ones, placed to test R4, and it withdraws them before any request completes. It raises `start` while busy only to show that the pulse is ignored.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  typedef enum logic [2:0] {
    MODE_INH = 3'd0,
    MODE_IMM = 3'd1,
    MODE_DIR = 3'd2,
    MODE_REL = 3'd3,
    MODE_IDX = 3'd4,
    MODE_EXT = 3'd5
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH1,
    ST_FETCH2,
    ST_DONE
  } fstate_e;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] PAGE_LO = 8'h10;
  localparam logic [BYTE_W-1:0] PAGE_HI = 8'h11;
endpackage

// File: rtl/opdec_mode_map.sv
module opdec_mode_map
  import opdec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output amode_e            mode
);
  logic [3:0] row;
  logic [3:0] col;

  assign row = word[7:4];
  assign col = word[3:0];

  always_comb begin
    mode = MODE_INH;
    case (row)
      4'h0, 4'h9, 4'hD: mode = MODE_DIR;
      4'h2:             mode = MODE_REL;
      4'h6, 4'hA, 4'hE: mode = MODE_IDX;
      4'h7, 4'hB, 4'hF: mode = MODE_EXT;
      4'h8, 4'hC:       mode = (word == 16'h008D) ? MODE_REL : MODE_IMM;
      4'h3, 4'h4, 4'h5: begin
        // whole word compared: prefixed words here fall through to inherent
        if (word < 16'h0034)
          mode = MODE_IDX;
        else if (word < 16'h0038 || word == 16'h003C)
          mode = MODE_IMM;
        else
          mode = MODE_INH;
      end
      4'h1: begin
        case (col)
          4'h6, 4'h7:             mode = MODE_REL;
          4'hA, 4'hC, 4'hE, 4'hF: mode = MODE_IMM;
          default:                mode = MODE_INH;
        endcase
      end
      default: mode = MODE_INH;
    endcase
  end
endmodule

// File: rtl/opdec_fetch_fsm.sv
module opdec_fetch_fsm
  import opdec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_pc,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_ready,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word,
  output logic [ADDR_W-1:0] pc,
  output logic              busy,
  output logic              done
);
  fstate_e           state_q;
  logic              sent_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] word_q;
  logic              fetching;
  logic              is_page;
  logic              req_fire;
  logic              rsp_fire;

  assign fetching = (state_q == ST_FETCH1) || (state_q == ST_FETCH2);
  assign is_page  = (rsp_data == PAGE_LO) || (rsp_data == PAGE_HI);

  assign req_valid  = fetching && !sent_q;
  assign rsp_ready  = fetching && sent_q;
  assign req_fire   = req_valid && req_ready;
  assign rsp_fire   = rsp_ready && rsp_valid;
  assign req_addr   = pc_q;
  assign pc         = pc_q;
  assign word       = word_q;
  assign word_valid = (state_q == ST_DONE);
  assign busy       = (state_q != ST_IDLE);
  assign done       = word_valid && word_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
      pc_q    <= '0;
      word_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            pc_q    <= start_pc;
            sent_q  <= 1'b0;
            word_q  <= '0;
            state_q <= ST_FETCH1;
          end
        end
        ST_FETCH1, ST_FETCH2: begin
          if (req_fire) begin
            pc_q   <= pc_q + 1'b1;
            sent_q <= 1'b1;
          end
          if (rsp_fire) begin
            sent_q <= 1'b0;
            if (state_q == ST_FETCH1) begin
              if (is_page) begin
                word_q  <= {rsp_data, {BYTE_W{1'b0}}};
                state_q <= ST_FETCH2;
              end else begin
                word_q  <= {{BYTE_W{1'b0}}, rsp_data};
                state_q <= ST_DONE;
              end
            end else begin
              // second byte is never treated as a prefix
              word_q[BYTE_W-1:0] <= rsp_data;
              state_q            <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (word_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opcode_fetch_decode.sv
module opcode_fetch_decode
  import opdec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_pc,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              rsp_ready,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [15:0]       dec_word,
  output logic [2:0]        dec_mode,
  output logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] pc
);
  logic [WORD_W-1:0] word_w;
  amode_e            mode_w;

  opdec_fetch_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_pc   (start_pc),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_ready  (rsp_ready),
    .word_valid (dec_valid),
    .word_ready (dec_ready),
    .word       (word_w),
    .pc         (pc),
    .busy       (busy),
    .done       (done)
  );

  opdec_mode_map u_map (
    .word (word_w),
    .mode (mode_w)
  );

  assign dec_word = word_w;
  assign dec_mode = mode_w;
endmodule

// File: rtl/opcode_fetch_decode_chk.sv
module opcode_fetch_decode_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_ready,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic [15:0]       dec_word,
  input logic [2:0]        dec_mode,
  input logic              done,
  input logic              busy,
  input logic [ADDR_W-1:0] pc
);
  // R1: idle block drives no request and no result
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !dec_valid && !rsp_ready));

  // R3: request held with stable address under back-pressure
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R3: accepted request advances the fetch address by one
  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (pc == $past(pc) + 1'b1));

  // R4: request and response phases never overlap
  a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R5: a nonzero upper byte is always a page prefix
  a_r5_upper_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_word[15:8] != 8'h00) |->
      (dec_word[15:8] == 8'h10 || dec_word[15:8] == 8'h11));

  // R7: only the six defined mode codes appear
  a_r7_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_mode <= 3'd5));

  // R12: result held until taken
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=>
      (dec_valid && $stable(dec_word) && $stable(dec_mode)));

  // R12: after the handshake the block is idle
  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!dec_valid && !busy));
endmodule

bind opcode_fetch_decode opcode_fetch_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_ready (rsp_ready),
  .dec_valid (dec_valid),
  .dec_ready (dec_ready),
  .dec_word  (dec_word),
  .dec_mode  (dec_mode),
  .done      (done),
  .busy      (busy),
  .pc        (pc)
);

// File: tb/opcode_fetch_decode_tb_top.sv
module opcode_fetch_decode_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 41;
  // {first byte, second byte, expected word, expected mode}
  localparam logic [34:0] VEC [NV] = '{
    {8'h12, 8'h00, 16'h0012, 3'd0}, {8'h16, 8'h00, 16'h0016, 3'd3},
    {8'h17, 8'h00, 16'h0017, 3'd3}, {8'h1C, 8'h00, 16'h001C, 3'd1},
    {8'h1F, 8'h00, 16'h001F, 3'd1}, {8'h19, 8'h00, 16'h0019, 3'd0},
    {8'h14, 8'h00, 16'h0014, 3'd0}, {8'h1E, 8'h00, 16'h001E, 3'd1},
    {8'h0C, 8'h00, 16'h000C, 3'd2}, {8'h27, 8'h00, 16'h0027, 3'd3},
    {8'h30, 8'h00, 16'h0030, 3'd4}, {8'h33, 8'h00, 16'h0033, 3'd4},
    {8'h34, 8'h00, 16'h0034, 3'd1}, {8'h37, 8'h00, 16'h0037, 3'd1},
    {8'h38, 8'h00, 16'h0038, 3'd0}, {8'h3C, 8'h00, 16'h003C, 3'd1},
    {8'h3D, 8'h00, 16'h003D, 3'd0}, {8'h4F, 8'h00, 16'h004F, 3'd0},
    {8'h5A, 8'h00, 16'h005A, 3'd0}, {8'h6E, 8'h00, 16'h006E, 3'd4},
    {8'h7E, 8'h00, 16'h007E, 3'd5}, {8'h86, 8'h00, 16'h0086, 3'd1},
    {8'h8D, 8'h00, 16'h008D, 3'd3}, {8'h9D, 8'h00, 16'h009D, 3'd2},
    {8'hAD, 8'h00, 16'h00AD, 3'd4}, {8'hBD, 8'h00, 16'h00BD, 3'd5},
    {8'hC6, 8'h00, 16'h00C6, 3'd1}, {8'hDC, 8'h00, 16'h00DC, 3'd2},
    {8'hEC, 8'h00, 16'h00EC, 3'd4}, {8'hFE, 8'h00, 16'h00FE, 3'd5},
    {8'h10, 8'h83, 16'h1083, 3'd1}, {8'h10, 8'h8D, 16'h108D, 3'd1},
    {8'h10, 8'h3F, 16'h103F, 3'd0}, {8'h11, 8'h8C, 16'h118C, 3'd1},
    {8'h10, 8'h27, 16'h1027, 3'd3}, {8'h10, 8'hDE, 16'h10DE, 3'd2},
    {8'h10, 8'hAE, 16'h10AE, 3'd4}, {8'h10, 8'hBE, 16'h10BE, 3'd5},
    {8'h10, 8'h30, 16'h1030, 3'd0}, {8'h10, 8'h10, 16'h1010, 3'd0},
    {8'h11, 8'h11, 16'h1111, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_pc = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [15:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        rsp_ready;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [15:0] dec_word;
  logic [2:0]  dec_mode;
  logic        done;
  logic        busy;
  logic [15:0] pc;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opcode_fetch_decode #(.ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_word(dec_word),
    .dec_mode(dec_mode), .done(done), .busy(busy), .pc(pc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [7:0] b0, input logic [15:0] w);
    if (b0 == 8'h10 || b0 == 8'h11) return "R11";
    if (w == 16'h008D)              return "R8";
    if (w[7:4] >= 4'h3 && w[7:4] <= 4'h5) return "R9";
    if (w[7:4] == 4'h1)             return "R10";
    return "R7";
  endfunction

  // serve one full fetch and decode from base address
  task automatic run_one(input logic [15:0] base, input logic [7:0] b0,
                         input logic [7:0] b1, input logic [15:0] ew,
                         input logic [2:0] em);
    int k = 0;
    int guard = 0;
    int nexp;
    nexp = (b0 == 8'h10 || b0 == 8'h11) ? 2 : 1;
    @(negedge clk); start = 1'b1; start_pc = base;
    @(negedge clk); start = 1'b0;
    while (!dec_valid && guard < 40) begin
      if (req_valid) begin
        chk(req_addr == base + 16'(k), "R3 request address", 32'(req_addr),
            32'(base + 16'(k)));
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = (k == 0) ? b0 : b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        k++;
      end else begin
        @(negedge clk);
      end
      guard++;
    end
    chk(k == nexp, "R6 fetch count", 32'(k), 32'(nexp));
    chk(dec_word == ew, "R5 word", 32'(dec_word), 32'(ew));
    chk(dec_mode == em, mode_tag(b0, ew), 32'(dec_mode), 32'(em));
    chk(pc == base + 16'(nexp), "R3 next pc", 32'(pc), 32'(base + 16'(nexp)));
    dec_ready = 1'b1;
    #1;
    chk(done == 1'b1, "R12 done strobe", 32'(done), 32'd1);
    @(negedge clk);
    dec_ready = 1'b0;
    chk(!busy && !dec_valid && !done, "R12 back to idle",
        {29'd0, busy, dec_valid, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !req_valid && !dec_valid, "R1 reset outputs",
        {29'd0, busy, req_valid, dec_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid && !dec_valid, "R1 after reset",
        {29'd0, busy, req_valid, dec_valid}, 32'd0);

    // R4: response while idle is ignored
    rsp_valid = 1'b1; rsp_data = 8'h86;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !dec_valid && !rsp_ready, "R4 idle response ignored",
        {29'd0, busy, dec_valid, rsp_ready}, 32'd0);
    rsp_valid = 1'b0;

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      run_one(16'h0100 + 16'(i * 4), VEC[i][34:27], VEC[i][26:19],
              VEC[i][18:3], VEC[i][2:0]);
    end

    // R3: address wrap across a prefix
    run_one(16'hFFFF, 8'h10, 8'h8E, 16'h108E, 3'd1);

    // R2, R3, R4, R12: back-pressure and ignored inputs
    req_ready = 1'b0;
    @(negedge clk); start = 1'b1; start_pc = 16'h2000;
    @(negedge clk); start = 1'b0;
    chk(busy && req_valid, "R2 start raises request", {30'd0, busy, req_valid}, 32'd3);
    rsp_valid = 1'b1; rsp_data = 8'h86;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(req_valid && req_addr == 16'h2000 && pc == 16'h2000, "R3 hold under back-pressure",
          32'(req_addr), 32'h2000);
      chk(!rsp_ready, "R4 no response before request", 32'(rsp_ready), 32'd0);
    end
    rsp_valid = 1'b0;
    req_ready = 1'b1;
    @(negedge clk);
    chk(!req_valid && pc == 16'h2001, "R3 accept advances pc", 32'(pc), 32'h2001);
    rsp_valid = 1'b1; rsp_data = 8'h8D;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(dec_valid && dec_mode == 3'd3, "R8 relative exception", 32'(dec_mode), 32'd3);
    start = 1'b1; start_pc = 16'h3000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(dec_valid && dec_word == 16'h008D, "R12 result held", 32'(dec_word), 32'h008D);
      chk(pc == 16'h2001, "R2 start while busy ignored", 32'(pc), 32'h2001);
    end
    start = 1'b0;
    dec_ready = 1'b1;
    #1;
    chk(done, "R12 done on handshake", 32'(done), 32'd1);
    @(negedge clk);
    dec_ready = 1'b0;
    chk(!busy && !done, "R12 idle after handshake", {30'd0, busy, done}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule